// File: doc/BRIEF.md
# Event pulse clock-domain crossing

This block carries single-cycle event pulses from one clock domain into an unrelated one. A one-cycle strobe on the source side becomes a one-cycle strobe in the destination domain some cycles later. The source side needs no knowledge of the destination clock, and the destination side needs none of the source clock.

A transfer is a change of level on a request line. The destination synchronizes that line and turns each change into one output pulse. It then returns the new level as an acknowledgement, which the source synchronizes in turn. The source is busy from the launch of a transfer until the matching acknowledgement arrives. An event that arrives while the source is busy is held in a waiting flag. The flag launches a new transfer as soon as the source becomes idle. Further events that arrive while the flag is already set add nothing, so a fast burst collapses into fewer output pulses, but the last event of any burst is always followed by an output pulse.

Both crossings use a synchronizer chain whose depth is a parameter (two registers by default). Resets are asynchronous and active low. Each reset is expected to be released synchronously to its own clock.

Top module: `evt_pulse_xfer`

## Requirements
- R1: While reset and after reset, with no source event, `dst_evt_o` stays low.
- R2: A single isolated source event produces exactly one destination pulse.
- R3: A burst of N source events produces at least 1 and at most N destination pulses. At least one of those pulses occurs after the last event of the burst.
- R4: `dst_evt_o` is high for exactly one destination-clock cycle per pulse and is never high in two consecutive destination cycles.
- R5: The running count of destination pulses never exceeds the running count of source events. No pulse appears without an earlier event.
- R6: An event that arrives while a transfer is outstanding is held and launched once the acknowledgement returns, so that event is followed by a later destination pulse of its own.
- R7: When an event arrives in the same source cycle in which the acknowledgement ends the busy state, that event launches a new transfer at once and is neither lost nor duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous active-low reset |
| src_evt_i | input | 1 | One-cycle event strobe in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous active-low reset |
| dst_evt_o | output | 1 | One-cycle event strobe in the destination domain |

## Verification
Two things can fall in the same source cycle: a new event arriving, and the returning acknowledgement ending the busy state. The bench provokes this by sending a second event at every offset from 0 to 30 source cycles after the first. Some of those offsets land on the cycle in which the acknowledgement lands. For every offset, the bench requires one or two pulses, a pulse after the second event, and exactly two pulses once the gap exceeds a full round trip. Random bursts on two unrelated clock periods hit the same collision again, and each is judged against the 1-to-N bounds and the no-spurious-pulse rule.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;
  // default synchronizer depth on each crossing
  localparam int SYNC_DEPTH_DEF = 2;
  // states of the source side
  typedef enum logic [1:0] {
    SRC_IDLE    = 2'b00,
    SRC_BUSY    = 2'b01,
    SRC_WAITING = 2'b11
  } src_state_e;
endpackage

// File: rtl/evt_sync_chain.sv
module evt_sync_chain #(
  parameter int STAGES = evt_xfer_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end else begin : g_single
      always_comb chain_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_src_ctrl.sv
module evt_src_ctrl
  import evt_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic ack_i,
  output logic req_o
);
  logic       req_q, req_d;
  logic       wait_q, wait_d;
  logic       busy;
  logic       launch_en;
  src_state_e state;

  assign busy      = req_q ^ ack_i;
  assign launch_en = !busy && (wait_q || evt_i);

  always_comb begin
    state = SRC_IDLE;
    if (busy) state = wait_q ? SRC_WAITING : SRC_BUSY;
  end

  always_comb begin
    req_d  = req_q;
    wait_d = wait_q;
    if (launch_en) begin
      req_d  = ~req_q;
      wait_d = 1'b0;
    end else if (evt_i) begin
      wait_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      wait_q <= wait_d;
    end
  end

  assign req_o = req_q;

  AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (wait_q || (req_q != $past(req_q)))); // R6
  AST_WAIT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SRC_IDLE && wait_q) |=> (req_q != $past(req_q))); // R7
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SRC_IDLE) |=> (req_q == $past(req_q))); // R5
  AST_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SRC_IDLE && evt_i) |=> (req_q != $past(req_q) && !wait_q)); // R7
endmodule

// File: rtl/evt_dst_ctrl.sv
module evt_dst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync_i,
  output logic ack_o,
  output logic pulse_o
);
  logic seen_q,  seen_d;
  logic pulse_q, pulse_d;
  logic edge_en;

  assign edge_en = req_sync_i ^ seen_q;

  always_comb begin
    seen_d  = edge_en ? req_sync_i : seen_q;
    pulse_d = edge_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign ack_o   = seen_q;
  assign pulse_o = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R4
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (seen_q != $past(seen_q))); // R5
endmodule

// File: rtl/evt_pulse_xfer.sv
module evt_pulse_xfer #(
  parameter int SYNC_STAGES = evt_xfer_pkg::SYNC_DEPTH_DEF
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_evt_i,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_evt_o
);
  logic req_src;
  logic req_dst;
  logic ack_dst;
  logic ack_src;

  evt_src_ctrl u_src (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .evt_i (src_evt_i),
    .ack_i (ack_src),
    .req_o (req_src)
  );

  evt_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d_i   (req_src),
    .q_o   (req_dst)
  );

  evt_dst_ctrl u_dst (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n),
    .req_sync_i (req_dst),
    .ack_o      (ack_dst),
    .pulse_o    (dst_evt_o)
  );

  evt_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d_i   (ack_dst),
    .q_o   (ack_src)
  );
endmodule

// File: tb/evt_pulse_xfer_tb.sv
module evt_pulse_xfer_tb;
  localparam int SRC_PERIOD = 10;
  localparam int DST_PERIOD = 14;
  localparam int QUIET      = 60;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_evt = 1'b0;
  logic dst_evt;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int ev_sent = 0, pulses = 0;
  bit prev_hi = 1'b0;
  bit done = 1'b0;

  always #(SRC_PERIOD/2) src_clk = ~src_clk;
  always #(DST_PERIOD/2) dst_clk = ~dst_clk;

  evt_pulse_xfer u_dut (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_evt_i (src_evt),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_evt_o (dst_evt)
  );

  function automatic bit in_bounds(int got, int lo, int hi);
    return (got >= lo) && (got <= hi);
  endfunction

  task automatic check(bit ok, string req, int act, int exp_lo, int exp_hi);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  // monitor on the destination side, sampled away from the active edge
  always @(negedge dst_clk) begin
    if (dst_rst_n && !done) begin
      if (dst_evt) begin
        pulses++;
        mon_checks++;
        if (prev_hi) begin // R4
          mon_fails++;
          $display("FAIL R4: actual high %0d cycles expected 1", 2);
        end
        mon_checks++;
        if (pulses > ev_sent) begin // R5
          mon_fails++;
          $display("FAIL R5: actual pulses %0d expected <= %0d", pulses, ev_sent);
        end
      end
      prev_hi = dst_evt;
    end
  end

  task automatic send_evt();
    @(negedge src_clk);
    src_evt = 1'b1;
    ev_sent++;
    @(negedge src_clk);
    src_evt = 1'b0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge src_clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge src_clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
             checks + mon_checks + 1);
    $finish;
  end

  initial begin : main
    int base, after_last, n, d;
    void'($urandom(32'h5eed_1234));
    #35;
    check(dst_evt == 1'b0, "R1 in reset", dst_evt, 0, 0);
    #65;
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    gap(20);
    check(dst_evt == 1'b0 && pulses == 0, "R1 idle after reset", pulses, 0, 0);

    // R2: single isolated event
    base = pulses;
    send_evt();
    gap(QUIET);
    check(pulses - base == 1, "R2 single event", pulses - base, 1, 1);

    // R6: second event sent right after the first pulse is seen
    base = pulses;
    send_evt();
    while (pulses == base) @(negedge src_clk);
    send_evt();
    gap(QUIET);
    check(pulses - base == 2, "R6 event during acknowledge", pulses - base, 2, 2);

    // R7: second event at every offset, colliding with the ack at some of them
    for (int off = 0; off <= 30; off++) begin
      base = pulses;
      send_evt();
      gap(off);
      send_evt();
      after_last = pulses;
      gap(QUIET);
      check(in_bounds(pulses - base, 1, 2), "R7 offset bounds", pulses - base, 1, 2);
      check(pulses > after_last, "R7 pulse after second event", pulses - after_last, 1, 2);
      if (off >= 25)
        check(pulses - base == 2, "R7 spaced events", pulses - base, 2, 2);
    end

    // R3: random bursts
    for (int b = 0; b < 40; b++) begin
      base = pulses;
      n = 1 + int'($urandom_range(0, 7));
      for (int k = 0; k < n; k++) begin
        send_evt();
        d = int'($urandom_range(0, 4));
        if (k != n - 1) gap(d);
      end
      after_last = pulses;
      gap(QUIET);
      check(in_bounds(pulses - base, 1, n), "R3 burst bounds", pulses - base, 1, n);
      check(pulses > after_last, "R3 pulse after last event", pulses - after_last, 1, n);
    end

    // R1/R5: long quiet period, no stray pulse
    base = pulses;
    gap(200);
    check(pulses == base, "R5 no pulse without event", pulses - base, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
             checks + mon_checks);
    $finish;
  end
endmodule